// File: doc/BRIEF.md
# Supply Monitor Status and Alert Logic

This block turns two digital supply-monitor comparator flags into latched status bits, an active-low alert line and a shutdown response. The low-supply warning flag (the brownout comparator) sets a sticky status bit and raises the alert. A read of the status byte drops the alert. The sticky bit stays set until software has toggled a control bit low, high and low again and has then read the status byte while the warning flag is inactive.

The deep-undervoltage flag (the shutdown comparator) is handled only when no higher pack voltage is present. In that case it sets a second status bit that simply follows the condition. While that bit is set, every FET enable is held off and a sleep request is raised. This condition never touches the alert.

An 8-bit configuration byte holds two 4-bit threshold codes. The block decodes each code into a threshold in millivolts, which is passed to the analog comparators.

Top module: `supmon_status`

## Requirements
- R1: After reset the status byte is 0x00, `alert_n` is 1, both threshold codes are 0, `bo_thr_mv` is 7975, `sd_thr_mv` is 6475, `sleep_req` is 0 and `fet_en` equals `fet_req`.
- R2: When `bo_flag` is high at a clock edge, status bit 4 is 1 after that edge. A 0-to-1 change of `bo_flag` drives `alert_n` low after the same edge.
- R3: A cycle with `stat_rd` high and no rising `bo_flag` makes `alert_n` 1 after that edge. Status bit 4 is left as it was.
- R4: Status bit 4 clears only on a `stat_rd` cycle that follows this sequence while the bit is set: `ctl_bit` seen at 0, then at 1, then at 0, each level held for at least one cycle. `bo_flag` must also be low on that read cycle. A read without the sequence, or the sequence without a read, leaves the bit at 1.
- R5: If `bo_flag` is high on the read that completes the clearing sequence, bit 4 stays at 1 and the sequence is discarded. A later read needs a fresh 0-1-0 sequence before it can clear the bit.
- R6: A new rising edge of `bo_flag` after the alert has been released drives `alert_n` low again. When that edge falls in the same cycle as `stat_rd`, `alert_n` goes or stays low.
- R7: `cfg_wdata` is stored when `cfg_we` is high. Bits 7:4 give the brownout code, with `bo_thr_mv` = 7975 + 300*code. Bits 3:0 give the shutdown code, with `sd_thr_mv` = 6475 + 300*code.
- R8: When `sd_flag` is 1 and `pack_hi` is 0 at a clock edge, status bit 5 is 1 after that edge. While bit 5 is 1, `fet_en` is all zero and `sleep_req` is 1. While bit 5 is 0, `fet_en` equals `fet_req` (bit 0 charge, bit 1 discharge, bit 2 precharge).
- R9: Status bit 5 is 0 after any edge at which `sd_flag` is 0 or `pack_hi` is 1.
- R10: The shutdown condition never changes `alert_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bo_flag | input | 1 | Brownout comparator output, 1 = supply below warning level |
| sd_flag | input | 1 | Shutdown comparator output, 1 = supply below shutdown level |
| pack_hi | input | 1 | 1 = a higher pack voltage is present |
| ctl_bit | input | 1 | Control bit used for the brownout clearing sequence |
| stat_rd | input | 1 | One-cycle strobe marking a read of the status byte |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_wdata | input | 8 | Configuration byte write data |
| fet_req | input | 3 | FET enables requested by the protection logic |
| stat_byte | output | 8 | Status byte: bit 4 brownout, bit 5 shutdown, others 0 |
| alert_n | output | 1 | Active-low level alert |
| fet_en | output | 3 | FET enables after the shutdown override |
| sleep_req | output | 1 | Request to enter sleep |
| bo_code | output | 4 | Stored brownout threshold code |
| sd_code | output | 4 | Stored shutdown threshold code |
| bo_thr_mv | output | 14 | Brownout threshold in millivolts |
| sd_thr_mv | output | 14 | Shutdown threshold in millivolts |

## Verification
Two events can land on the same edge. One is a status read that releases the alert while a fresh brownout edge tries to raise it. The other is the read that completes the clearing sequence while the brownout flag is still high. The bench drives the read strobe and the rising flag in the same cycle and expects the alert to stay low. It also completes a full 0-1-0 sequence with the flag still high, then expects bit 4 to survive both that read and a second, unprimed read. Bit 4 may only drop after a new sequence.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  localparam int MV_W   = 14;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    CLR_IDLE  = 2'd0,
    CLR_LOW   = 2'd1,
    CLR_HIGH  = 2'd2,
    CLR_ARMED = 2'd3
  } clr_state_e;

  // threshold in millivolts = base + step * code
  function automatic logic [MV_W-1:0] code_to_mv(
    input logic [MV_W-1:0]   base,
    input logic [MV_W-1:0]   step,
    input logic [CODE_W-1:0] code
  );
    return base + step * MV_W'(code);
  endfunction

endpackage

// File: rtl/supmon_cfg.sv
module supmon_cfg
  import supmon_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int BO_BASE_MV = 7975,
  parameter int SD_BASE_MV = 6475,
  parameter int STEP_MV    = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CODE_W-1:0] bo_code,
  output logic [CODE_W-1:0] sd_code,
  output logic [MV_W-1:0]   bo_thr_mv,
  output logic [MV_W-1:0]   sd_thr_mv
);
  localparam int HALF = CFG_W / 2;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  // upper half: brownout code, lower half: shutdown code
  assign bo_code = cfg_q[CFG_W-1:HALF];
  assign sd_code = cfg_q[HALF-1:0];

  assign bo_thr_mv = code_to_mv(MV_W'(BO_BASE_MV), MV_W'(STEP_MV), bo_code);
  assign sd_thr_mv = code_to_mv(MV_W'(SD_BASE_MV), MV_W'(STEP_MV), sd_code);

endmodule

// File: rtl/supmon_clr_fsm.sv
module supmon_clr_fsm
  import supmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,     // brownout bit currently set
  input  logic ctl_bit,
  input  logic stat_rd,
  input  logic bo_flag,
  output logic clr_fire,   // clear the brownout bit at the next edge
  output logic armed
);
  clr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!active) begin
      st_d = CLR_IDLE;
    end else begin
      case (st_q)
        CLR_IDLE:  if (!ctl_bit) st_d = CLR_LOW;
        CLR_LOW:   if (ctl_bit)  st_d = CLR_HIGH;
        CLR_HIGH:  if (!ctl_bit) st_d = CLR_ARMED;
        CLR_ARMED: if (stat_rd)  st_d = CLR_IDLE;
        default:   st_d = CLR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CLR_IDLE;
    else        st_q <= st_d;
  end

  assign armed    = (st_q == CLR_ARMED);
  assign clr_fire = armed & stat_rd & ~bo_flag;

endmodule

// File: rtl/supmon_bo_stat.sv
module supmon_bo_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic bo_flag,
  input  logic stat_rd,
  input  logic clr_fire,
  output logic brown_stat,
  output logic alert_q,
  output logic bo_rise
);
  logic bo_d;

  assign bo_rise = bo_flag & ~bo_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_d       <= 1'b0;
      brown_stat <= 1'b0;
      alert_q    <= 1'b0;
    end else begin
      bo_d       <= bo_flag;
      // a present flag always wins over a clear
      brown_stat <= bo_flag | (brown_stat & ~clr_fire);
      // a fresh edge always wins over a release
      alert_q    <= bo_rise | (alert_q & ~stat_rd);
    end
  end

endmodule

// File: rtl/supmon_sd_guard.sv
module supmon_sd_guard #(
  parameter int FET_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd_flag,
  input  logic             pack_hi,
  input  logic [FET_N-1:0] fet_req,
  output logic             shut_stat,
  output logic [FET_N-1:0] fet_en,
  output logic             sleep_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shut_stat <= 1'b0;
    else        shut_stat <= sd_flag & ~pack_hi;
  end

  for (genvar g = 0; g < FET_N; g++) begin : g_gate
    assign fet_en[g] = fet_req[g] & ~shut_stat;
  end

  assign sleep_req = shut_stat;

endmodule

// File: rtl/supmon_status.sv
module supmon_status
  import supmon_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int STAT_W     = 8,
  parameter int BO_BIT     = 4,
  parameter int SD_BIT     = 5,
  parameter int FET_N      = 3,
  parameter int BO_BASE_MV = 7975,
  parameter int SD_BASE_MV = 6475,
  parameter int STEP_MV    = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bo_flag,
  input  logic              sd_flag,
  input  logic              pack_hi,
  input  logic              ctl_bit,
  input  logic              stat_rd,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [FET_N-1:0]  fet_req,
  output logic [STAT_W-1:0] stat_byte,
  output logic              alert_n,
  output logic [FET_N-1:0]  fet_en,
  output logic              sleep_req,
  output logic [CODE_W-1:0] bo_code,
  output logic [CODE_W-1:0] sd_code,
  output logic [MV_W-1:0]   bo_thr_mv,
  output logic [MV_W-1:0]   sd_thr_mv
);
  logic brown_stat, shut_stat, alert_q, bo_rise, clr_fire, armed;

  supmon_cfg #(
    .CFG_W(CFG_W), .BO_BASE_MV(BO_BASE_MV),
    .SD_BASE_MV(SD_BASE_MV), .STEP_MV(STEP_MV)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bo_code(bo_code), .sd_code(sd_code),
    .bo_thr_mv(bo_thr_mv), .sd_thr_mv(sd_thr_mv)
  );

  supmon_clr_fsm u_clr (
    .clk(clk), .rst_n(rst_n), .active(brown_stat), .ctl_bit(ctl_bit),
    .stat_rd(stat_rd), .bo_flag(bo_flag), .clr_fire(clr_fire), .armed(armed)
  );

  supmon_bo_stat u_bo (
    .clk(clk), .rst_n(rst_n), .bo_flag(bo_flag), .stat_rd(stat_rd),
    .clr_fire(clr_fire), .brown_stat(brown_stat), .alert_q(alert_q),
    .bo_rise(bo_rise)
  );

  supmon_sd_guard #(.FET_N(FET_N)) u_sd (
    .clk(clk), .rst_n(rst_n), .sd_flag(sd_flag), .pack_hi(pack_hi),
    .fet_req(fet_req), .shut_stat(shut_stat), .fet_en(fet_en),
    .sleep_req(sleep_req)
  );

  always_comb begin
    stat_byte         = '0;
    stat_byte[BO_BIT] = brown_stat;
    stat_byte[SD_BIT] = shut_stat;
  end

  assign alert_n = ~alert_q;

endmodule

// File: rtl/supmon_status_chk.sv
module supmon_status_chk #(
  parameter int STAT_W     = 8,
  parameter int BO_BIT     = 4,
  parameter int SD_BIT     = 5,
  parameter int FET_N      = 3,
  parameter int MV_W       = 14,
  parameter int BO_BASE_MV = 7975,
  parameter int STEP_MV    = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bo_flag,
  input logic              sd_flag,
  input logic              pack_hi,
  input logic              stat_rd,
  input logic              bo_rise,
  input logic              armed,
  input logic [STAT_W-1:0] stat_byte,
  input logic              alert_n,
  input logic [FET_N-1:0]  fet_en,
  input logic              sleep_req,
  input logic [MV_W-1:0]   bo_thr_mv
);
  localparam logic [MV_W-1:0] BO_MAX = MV_W'(BO_BASE_MV + 15 * STEP_MV);

  p_bo_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bo_flag |=> stat_byte[BO_BIT]);

  p_alert_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bo_rise |=> !alert_n);

  p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !bo_rise) |=> alert_n);

  p_clear_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_byte[BO_BIT]) |-> ($past(stat_rd) && $past(armed) && !$past(bo_flag)));

  p_flag_blocks_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && stat_rd && bo_flag) |=> (stat_byte[BO_BIT] && !armed));

  p_thr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_thr_mv >= MV_W'(BO_BASE_MV)) && (bo_thr_mv <= BO_MAX));

  p_sd_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_flag && !pack_hi) |=> stat_byte[SD_BIT]);

  p_sd_fets_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[SD_BIT] |-> (fet_en == '0 && sleep_req));

  p_sd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_flag || pack_hi) |=> !stat_byte[SD_BIT]);

  p_alert_only_brown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> $past(bo_rise));

endmodule

bind supmon_status supmon_status_chk #(
  .STAT_W(STAT_W), .BO_BIT(BO_BIT), .SD_BIT(SD_BIT), .FET_N(FET_N),
  .MV_W(supmon_pkg::MV_W), .BO_BASE_MV(BO_BASE_MV), .STEP_MV(STEP_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bo_flag(bo_flag), .sd_flag(sd_flag),
  .pack_hi(pack_hi), .stat_rd(stat_rd), .bo_rise(bo_rise), .armed(armed),
  .stat_byte(stat_byte), .alert_n(alert_n), .fet_en(fet_en),
  .sleep_req(sleep_req), .bo_thr_mv(bo_thr_mv)
);

// File: tb/supmon_status_tb.sv
module supmon_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bo_flag = 1'b0, sd_flag = 1'b0, pack_hi = 1'b0;
  logic        ctl_bit = 1'b0, stat_rd = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [2:0]  fet_req = 3'b111;
  logic [7:0]  stat_byte;
  logic        alert_n, sleep_req;
  logic [2:0]  fet_en;
  logic [3:0]  bo_code, sd_code;
  logic [13:0] bo_thr_mv, sd_thr_mv;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  supmon_status u_dut (
    .clk(clk), .rst_n(rst_n), .bo_flag(bo_flag), .sd_flag(sd_flag),
    .pack_hi(pack_hi), .ctl_bit(ctl_bit), .stat_rd(stat_rd),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .fet_req(fet_req),
    .stat_byte(stat_byte), .alert_n(alert_n), .fet_en(fet_en),
    .sleep_req(sleep_req), .bo_code(bo_code), .sd_code(sd_code),
    .bo_thr_mv(bo_thr_mv), .sd_thr_mv(sd_thr_mv)
  );

  function automatic int exp_mv(input int base, input int code);
    int v = base;
    for (int i = 0; i < code; i++) v += 300;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one edge passes; inputs change and outputs are sampled on the falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_read();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask

  task automatic ctl_pulse();
    ctl_bit = 1'b0; tick();
    ctl_bit = 1'b1; tick();
    ctl_bit = 1'b0; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", stat_byte, 0);
    chk("R1 alert_n", alert_n, 1);
    chk("R1 bo_code", bo_code, 0);
    chk("R1 sd_code", sd_code, 0);
    chk("R1 bo_thr", bo_thr_mv, 7975);
    chk("R1 sd_thr", sd_thr_mv, 6475);
    chk("R1 sleep", sleep_req, 0);
    chk("R1 fet_en", fet_en, 7);
  endtask

  task automatic t_brown_set_release();
    bo_flag = 1'b1; tick();
    chk("R2 bit4 set", stat_byte[4], 1);
    chk("R2 alert low", alert_n, 0);
    bo_flag = 1'b0; tick();
    chk("R2 alert held", alert_n, 0);
    do_read();
    chk("R3 alert released", alert_n, 1);
    chk("R3 bit4 kept", stat_byte[4], 1);
    do_read();
    chk("R4 read alone keeps bit4", stat_byte[4], 1);
  endtask

  task automatic t_clear_seq();
    ctl_pulse();
    tick();
    chk("R4 pulse alone keeps bit4", stat_byte[4], 1);
    do_read();
    chk("R4 bit4 cleared", stat_byte[4], 0);
    chk("R4 alert stays high", alert_n, 1);
  endtask

  task automatic t_flag_held();
    bo_flag = 1'b1; tick();
    chk("R6 realert", alert_n, 0);
    do_read();
    chk("R3 release with flag high", alert_n, 1);
    ctl_pulse();
    do_read();
    chk("R5 flag blocks clear", stat_byte[4], 1);
    bo_flag = 1'b0; tick();
    do_read();
    chk("R5 sequence discarded", stat_byte[4], 1);
    ctl_pulse();
    do_read();
    chk("R5 fresh sequence clears", stat_byte[4], 0);
  endtask

  task automatic t_collision();
    bo_flag = 1'b1; tick();
    bo_flag = 1'b0; tick();
    do_read();
    chk("R6 released before", alert_n, 1);
    bo_flag = 1'b1; stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    chk("R6 rise beats read", alert_n, 0);
    bo_flag = 1'b0; tick();
    do_read();
    ctl_pulse();
    do_read();
    chk("R4 cleanup clear", stat_byte[4], 0);
  endtask

  task automatic t_cfg();
    cfg_wdata = 8'hA3; tick();
    chk("R7 no write without enable", bo_thr_mv, 7975);
    cfg_we = 1'b1; tick(); cfg_we = 1'b0;
    chk("R7 bo_code", bo_code, 10);
    chk("R7 sd_code", sd_code, 3);
    chk("R7 bo_thr", bo_thr_mv, exp_mv(7975, 10));
    chk("R7 sd_thr", sd_thr_mv, exp_mv(6475, 3));
    cfg_wdata = 8'h0F; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
    chk("R7 bo_thr min", bo_thr_mv, 7975);
    chk("R7 sd_thr max", sd_thr_mv, exp_mv(6475, 15));
    cfg_wdata = 8'hF0; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
    chk("R7 bo_thr max", bo_thr_mv, exp_mv(7975, 15));
  endtask

  task automatic t_shutdown();
    fet_req = 3'b101; tick();
    chk("R8 passthrough", fet_en, 5);
    fet_req = 3'b111;
    sd_flag = 1'b1; tick();
    chk("R8 bit5 set", stat_byte[5], 1);
    chk("R8 fets off", fet_en, 0);
    chk("R8 sleep", sleep_req, 1);
    chk("R10 no alert", alert_n, 1);
    sd_flag = 1'b0; tick();
    chk("R9 bit5 clears", stat_byte[5], 0);
    chk("R9 fets back", fet_en, 7);
    pack_hi = 1'b1; sd_flag = 1'b1; tick();
    chk("R9 pack blocks", stat_byte[5], 0);
    chk("R9 sleep low", sleep_req, 0);
    pack_hi = 1'b0; tick();
    chk("R8 set after pack removed", stat_byte[5], 1);
    chk("R10 still no alert", alert_n, 1);
    sd_flag = 1'b0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_brown_set_release();
    t_clear_seq();
    t_flag_held();
    t_collision();
    t_cfg();
    t_shutdown();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule